// File: doc/BRIEF.md
# PWM Fault Trip Guard

This block sits on the path from a PWM generator to the output pins and drives the two PWM outputs to safe levels when a fault is reported. There are three fault sources. The first is an external active-low trip pin. The other two are compare events, A and B. Each compare event is the OR of the trip lines picked by its own select mask. Any source can be routed to the one-shot latch, to the cycle-by-cycle latch, or to both. Each has its own select bit for each latch.

Fault inputs reach the outputs through logic only, with no register in the path, so forcing takes effect in the same cycle as the fault. Flags, latches and the interrupt are registered on the clock. The cycle-by-cycle latch is released at a counter-zero strobe from the time base. It is released only if its fault has gone away. The one-shot latch is released only by software.

Software reads a flag vector and clears flags by writing a bit mask together with a write strobe. An interrupt pulse is raised when an enabled source trips while the interrupt flag is clear. A fresh pulse is also raised when the interrupt flag is cleared while other flags are still set.

Top module: `trip_guard`

## Requirements
- R1: With no trip latched and no trip active, outA equals pwmA and outB equals pwmB.
- R2: While any enabled trip is active or latched, each output follows its own 2-bit action code: 0 passes the PWM, 1 drives high, 2 drives low, 3 drives the inverted PWM. Forcing applies in the same cycle that the trip input goes low.
- R3: Compare event A is active when a trip line is low and its bit in dcSelA is set. Event B works the same way with dcSelB. A low line whose select bit is clear has no effect on the outputs or on the flags. Source bit positions: 0 is the pin, 1 is event A, 2 is event B.
- R4: A source whose ostEn bit is set sets the one-shot flag, flags[1]. This flag holds the outputs forced through trip release and through counter-zero strobes, until clrMask[1] is written.
- R5: A source whose cbcEn bit is set holds the outputs forced until the first ctrZero strobe at which no cycle-by-cycle trip is active. The outputs pass the PWM after that edge.
- R6: The cycle-by-cycle flag, flags[2], is set on every cycle in which a cycle-by-cycle trip is active. A clear written while the trip is active leaves the flag set.
- R7: flags[3] and flags[4] record compare events A and B. They are set whenever the event is active, whatever the latch selects are, and they are cleared through clrMask[3] and clrMask[4].
- R8: When an enabled interrupt cause occurs with flags[0] clear, tripIrq pulses for one cycle on the next cycle and flags[0] sets. No further pulse follows while flags[0] stays set. Enable bits in intEn: 0 is one-shot, 1 is cycle-by-cycle, 2 is event A, 3 is event B.
- R9: Clearing flags[0] while another flag remains set after the same write gives a new tripIrq pulse on the next cycle, and flags[0] stays set. Clearing with no other flag left gives no pulse.
- R10: When a trip assertion and a clear of the same flag happen in the same cycle, the flag ends up set.
- R11: After reset, all flags are 0, tripIrq is 0 and both latches are released.
- R12: A source whose interrupt enable is 0 still sets its flag but raises no interrupt pulse and leaves flags[0] clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| pwmA | input | 1 | PWM channel A from the generator |
| pwmB | input | 1 | PWM channel B from the generator |
| ctrZero | input | 1 | Counter-zero strobe from the time base |
| tripPinN | input | 1 | External trip pin, active low |
| tripLinesN | input | NUM_LINES | Trip lines, active low |
| dcSelA | input | NUM_LINES | Line mask for compare event A |
| dcSelB | input | NUM_LINES | Line mask for compare event B |
| ostEn | input | 3 | One-shot select per source |
| cbcEn | input | 3 | Cycle-by-cycle select per source |
| actA | input | 2 | Trip action for output A |
| actB | input | 2 | Trip action for output B |
| intEn | input | 4 | Interrupt enable per cause |
| clrWr | input | 1 | Clear write strobe |
| clrMask | input | 5 | Flags to clear on clrWr |
| outA | output | 1 | Guarded output A |
| outB | output | 1 | Guarded output B |
| flags | output | 5 | Interrupt, one-shot, cycle-by-cycle, event A and event B flags |
| tripIrq | output | 1 | Interrupt pulse |

## Verification
The action table is exercised with every action code on each output, against opposite PWM levels and against untripped vectors. This separates the pass, drive-high, drive-low and invert codes, and shows that a trip on one output leaves the other output's code independent. Trip lines are pulled low both inside and outside a compare mask, which separates masked lines from selected ones. One-shot and cycle-by-cycle trips are each released with the fault gone, with and without a zero strobe, which shows which latch needs software and which needs the time base. The interrupt is driven through a first trip, a repeat trip, a clear with other flags left set, a full clear, and a clear in the same cycle as a trip, which separates a first pulse, suppression, a re-pulse and set-wins-over-clear.

// File: rtl/tz_pkg.sv
package tz_pkg;

  typedef enum logic [1:0] {
    FA_PASS   = 2'd0,
    FA_HIGH   = 2'd1,
    FA_LOW    = 2'd2,
    FA_INVERT = 2'd3
  } forceAct_e;

  localparam int SRC_PIN = 0;
  localparam int SRC_DCA = 1;
  localparam int SRC_DCB = 2;
  localparam int NUM_SRC = 3;

  localparam int FLG_INT = 0;
  localparam int FLG_OST = 1;
  localparam int FLG_CBC = 2;
  localparam int FLG_DCA = 3;
  localparam int FLG_DCB = 4;
  localparam int NUM_FLG = 5;
  localparam int NUM_CAUSE = NUM_FLG - 1;

  // control -> datapath
  typedef struct packed {
    logic ostHold;
    logic cbcHold;
  } holdStb_t;

  // datapath -> control
  typedef struct packed {
    logic ostNow;
    logic cbcNow;
    logic dcaNow;
    logic dcbNow;
  } tripEvt_t;

endpackage

// File: rtl/tz_datapath.sv
module tz_datapath
  import tz_pkg::*;
#(
  parameter int NUM_LINES = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 pwmA,
  input  logic                 pwmB,
  input  logic                 tripPinN,
  input  logic [NUM_LINES-1:0] tripLinesN,
  input  logic [NUM_LINES-1:0] dcSelA,
  input  logic [NUM_LINES-1:0] dcSelB,
  input  logic [NUM_SRC-1:0]   ostEn,
  input  logic [NUM_SRC-1:0]   cbcEn,
  input  logic [1:0]           actA,
  input  logic [1:0]           actB,
  input  holdStb_t             hold,
  output tripEvt_t             evt,
  output logic                 outA,
  output logic                 outB
);

  localparam int NUM_OUT = 2;

  logic [NUM_LINES-1:0] lineAct;
  logic [NUM_SRC-1:0]   srcAct;
  logic                 forceAny;
  logic [NUM_OUT-1:0]   pwmVec;
  logic [NUM_OUT-1:0]   outVec;
  logic [NUM_OUT-1:0][1:0] actVec;

  assign lineAct         = ~tripLinesN;
  assign srcAct[SRC_PIN] = ~tripPinN;
  assign srcAct[SRC_DCA] = |(lineAct & dcSelA);
  assign srcAct[SRC_DCB] = |(lineAct & dcSelB);

  assign evt.ostNow = |(srcAct & ostEn);
  assign evt.cbcNow = |(srcAct & cbcEn);
  assign evt.dcaNow = srcAct[SRC_DCA];
  assign evt.dcbNow = srcAct[SRC_DCB];

  assign forceAny = hold.ostHold | hold.cbcHold | evt.ostNow | evt.cbcNow;

  assign pwmVec = {pwmB, pwmA};
  assign actVec = {actB, actA};

  for (genvar ch = 0; ch < NUM_OUT; ch++) begin : g_out
    always_comb begin
      outVec[ch] = pwmVec[ch];
      if (forceAny) begin
        case (forceAct_e'(actVec[ch]))
          FA_HIGH:   outVec[ch] = 1'b1;
          FA_LOW:    outVec[ch] = 1'b0;
          FA_INVERT: outVec[ch] = ~pwmVec[ch];
          default:   outVec[ch] = pwmVec[ch];
        endcase
      end
    end
  end

  assign outA = outVec[0];
  assign outB = outVec[1];

  // R2
  force_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    (hold.ostHold && actA == FA_LOW) |-> !outA);

  // R2
  force_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    (hold.cbcHold && actB == FA_HIGH) |-> outB);

endmodule

// File: rtl/tz_ctrl.sv
module tz_ctrl
  import tz_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  tripEvt_t             evt,
  input  logic                 ctrZero,
  input  logic [NUM_CAUSE-1:0] intEn,
  input  logic                 clrWr,
  input  logic [NUM_FLG-1:0]   clrMask,
  output holdStb_t             hold,
  output logic [NUM_FLG-1:0]   flags,
  output logic                 tripIrq
);

  logic [NUM_FLG-1:0]   flagQ, flagNext, clr;
  logic [NUM_CAUSE-1:0] causeVec;
  logic                 cbcLatchQ, cbcLatchNext;
  logic                 irqQ, irqNext;
  logic                 cause, otherNext, clrInt;

  assign clr      = clrWr ? clrMask : '0;
  assign clrInt   = clr[FLG_INT];
  assign causeVec = {evt.dcbNow, evt.dcaNow, evt.cbcNow, evt.ostNow};
  assign cause    = |(causeVec & intEn);

  // source flags: a set in this cycle beats a clear
  for (genvar f = FLG_OST; f < NUM_FLG; f++) begin : g_flag
    assign flagNext[f] = causeVec[f-1] | (flagQ[f] & ~clr[f]);
  end

  assign otherNext = |flagNext[NUM_FLG-1:FLG_OST];

  always_comb begin
    flagNext[FLG_INT] = cause | (flagQ[FLG_INT] & (~clrInt | otherNext));
    irqNext = (cause & ~flagQ[FLG_INT]) | (flagQ[FLG_INT] & clrInt & otherNext);
  end

  assign cbcLatchNext = evt.cbcNow | (cbcLatchQ & ~ctrZero);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flagQ     <= '0;
      cbcLatchQ <= 1'b0;
      irqQ      <= 1'b0;
    end else begin
      flagQ     <= flagNext;
      cbcLatchQ <= cbcLatchNext;
      irqQ      <= irqNext;
    end
  end

  assign hold.ostHold = flagQ[FLG_OST];
  assign hold.cbcHold = cbcLatchQ;
  assign flags        = flagQ;
  assign tripIrq      = irqQ;

  // R4
  ost_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (flagQ[FLG_OST] && !(clrWr && clrMask[FLG_OST])) |=> flagQ[FLG_OST]);

  // R5
  cbc_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cbcLatchQ && !ctrZero) |=> cbcLatchQ);

  // R10
  trip_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    evt.cbcNow |=> (flagQ[FLG_CBC] && cbcLatchQ));

  // R8
  irq_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqQ |-> flagQ[FLG_INT]);

endmodule

// File: rtl/trip_guard.sv
module trip_guard
  import tz_pkg::*;
#(
  parameter int NUM_LINES = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 pwmA,
  input  logic                 pwmB,
  input  logic                 ctrZero,
  input  logic                 tripPinN,
  input  logic [NUM_LINES-1:0] tripLinesN,
  input  logic [NUM_LINES-1:0] dcSelA,
  input  logic [NUM_LINES-1:0] dcSelB,
  input  logic [NUM_SRC-1:0]   ostEn,
  input  logic [NUM_SRC-1:0]   cbcEn,
  input  logic [1:0]           actA,
  input  logic [1:0]           actB,
  input  logic [NUM_CAUSE-1:0] intEn,
  input  logic                 clrWr,
  input  logic [NUM_FLG-1:0]   clrMask,
  output logic                 outA,
  output logic                 outB,
  output logic [NUM_FLG-1:0]   flags,
  output logic                 tripIrq
);

  holdStb_t hold;
  tripEvt_t evt;

  tz_datapath #(.NUM_LINES(NUM_LINES)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .pwmA       (pwmA),
    .pwmB       (pwmB),
    .tripPinN   (tripPinN),
    .tripLinesN (tripLinesN),
    .dcSelA     (dcSelA),
    .dcSelB     (dcSelB),
    .ostEn      (ostEn),
    .cbcEn      (cbcEn),
    .actA       (actA),
    .actB       (actB),
    .hold       (hold),
    .evt        (evt),
    .outA       (outA),
    .outB       (outB)
  );

  tz_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .evt     (evt),
    .ctrZero (ctrZero),
    .intEn   (intEn),
    .clrWr   (clrWr),
    .clrMask (clrMask),
    .hold    (hold),
    .flags   (flags),
    .tripIrq (tripIrq)
  );

endmodule

// File: tb/test_trip_guard.sv
module test_trip_guard;

  localparam int NL = 4;

  logic clk = 1'b0;
  logic rstN;
  logic pwmA, pwmB, ctrZero, tripPinN;
  logic [NL-1:0] tripLinesN, dcSelA, dcSelB;
  logic [2:0] ostEn, cbcEn;
  logic [1:0] actA, actB;
  logic [3:0] intEn;
  logic clrWr;
  logic [4:0] clrMask;
  logic outA, outB, tripIrq;
  logic [4:0] flags;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  trip_guard #(.NUM_LINES(NL)) i_trip_guard (
    .clk(clk), .rstN(rstN), .pwmA(pwmA), .pwmB(pwmB), .ctrZero(ctrZero),
    .tripPinN(tripPinN), .tripLinesN(tripLinesN), .dcSelA(dcSelA), .dcSelB(dcSelB),
    .ostEn(ostEn), .cbcEn(cbcEn), .actA(actA), .actB(actB), .intEn(intEn),
    .clrWr(clrWr), .clrMask(clrMask), .outA(outA), .outB(outB),
    .flags(flags), .tripIrq(tripIrq)
  );

  // [8:7] actA, [6:5] actB, [4] pwmA, [3] pwmB, [2] tripPinN, [1] expA, [0] expB
  localparam logic [8:0] VEC [8] = '{
    9'b10_01_1_0_0_0_1,
    9'b10_01_0_1_1_0_1,
    9'b00_00_1_0_0_1_0,
    9'b11_11_1_0_0_0_1,
    9'b01_10_0_1_0_1_0,
    9'b11_00_0_1_0_1_1,
    9'b01_01_1_1_1_1_1,
    9'b10_10_0_0_1_0_0
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic clearAll();
    clrWr = 1'b1; clrMask = 5'b11111;
    tick();
    clrWr = 1'b0; clrMask = 5'b0;
  endtask

  task automatic zeroStrobe();
    ctrZero = 1'b1;
    tick();
    ctrZero = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; pwmA = 1'b1; pwmB = 1'b0; ctrZero = 1'b0; tripPinN = 1'b1;
    tripLinesN = '1; dcSelA = '0; dcSelB = '0; ostEn = '0; cbcEn = '0;
    actA = 2'd2; actB = 2'd1; intEn = '0; clrWr = 1'b0; clrMask = '0;
    tick(); tick();
    // R11 reset state, R1 pass-through
    chk("R11 flags", 8'(flags), 8'h00);
    chk("R11 irq", 8'(tripIrq), 8'h0);
    chk("R1 outA", 8'(outA), 8'h1);
    chk("R1 outB", 8'(outB), 8'h0);
    rstN = 1'b1;
    tick();

    // R2 action table walk, cycle-by-cycle pin trip
    cbcEn = 3'b001;
    foreach (VEC[i]) begin
      actA = VEC[i][8:7]; actB = VEC[i][6:5];
      pwmA = VEC[i][4]; pwmB = VEC[i][3]; tripPinN = VEC[i][2];
      #1;
      chk($sformatf("R2 vec%0d outA", i), 8'(outA), 8'(VEC[i][1]));
      chk($sformatf("R2 vec%0d outB", i), 8'(outB), 8'(VEC[i][0]));
      tripPinN = 1'b1;
      zeroStrobe();
      clearAll();
    end
    cbcEn = '0;

    // R3 compare mask
    actA = 2'd2; actB = 2'd1; pwmA = 1'b1; pwmB = 1'b0;
    ostEn = 3'b010; dcSelA = 4'b0101; dcSelB = 4'b1000;
    tripLinesN = 4'b1101;
    #1;
    chk("R3 unselected line outA", 8'(outA), 8'h1);
    tick();
    chk("R3 unselected line flag", 8'(flags[3]), 8'h0);
    tripLinesN = 4'b1011;
    #1;
    chk("R3 selected line outA", 8'(outA), 8'h0);
    chk("R3 selected line outB", 8'(outB), 8'h1);
    tick();
    tripLinesN = '1;
    chk("R7 event A flag", 8'(flags[3]), 8'h1);
    chk("R3 event B untouched", 8'(flags[4]), 8'h0);
    chk("R4 one-shot flag from event A", 8'(flags[1]), 8'h1);
    clearAll();
    #1;
    chk("R7 flags cleared", 8'(flags), 8'h00);
    chk("R4 released by clear", 8'(outA), 8'h1);
    ostEn = '0; dcSelA = '0; dcSelB = '0;

    // R4 one-shot hold
    ostEn = 3'b001;
    tripPinN = 1'b0;
    tick();
    tripPinN = 1'b1;
    zeroStrobe();
    #1;
    chk("R4 still forced outA", 8'(outA), 8'h0);
    chk("R4 flag held", 8'(flags[1]), 8'h1);
    clrWr = 1'b1; clrMask = 5'b00010;
    tick();
    clrWr = 1'b0; clrMask = '0;
    chk("R4 released outA", 8'(outA), 8'h1);
    chk("R4 flag cleared", 8'(flags[1]), 8'h0);
    ostEn = '0;
    clearAll();

    // R5 cycle-by-cycle release
    cbcEn = 3'b001;
    tripPinN = 1'b0; ctrZero = 1'b1;
    tick();
    ctrZero = 1'b0; tripPinN = 1'b1;
    #1;
    chk("R5 zero while active keeps hold", 8'(outA), 8'h0);
    tick();
    chk("R5 held without zero", 8'(outA), 8'h0);
    zeroStrobe();
    chk("R5 released at zero", 8'(outA), 8'h1);
    chk("R5 outB back to pwm", 8'(outB), 8'h0);

    // R6 flag re-asserts while active
    clearAll();
    tripPinN = 1'b0;
    tick();
    chk("R6 flag set", 8'(flags[2]), 8'h1);
    clrWr = 1'b1; clrMask = 5'b00100;
    tick();
    chk("R6 clear while active ignored", 8'(flags[2]), 8'h1);
    tripPinN = 1'b1;
    tick();
    clrWr = 1'b0; clrMask = '0;
    chk("R6 clear after release", 8'(flags[2]), 8'h0);
    zeroStrobe();
    cbcEn = '0;
    clearAll();

    // R8 / R9 interrupt
    ostEn = 3'b001; intEn = 4'b0001;
    tripPinN = 1'b0;
    tick();
    tripPinN = 1'b1;
    chk("R8 first pulse", 8'(tripIrq), 8'h1);
    chk("R8 int flag", 8'(flags[0]), 8'h1);
    tick();
    chk("R8 pulse one cycle", 8'(tripIrq), 8'h0);
    tripPinN = 1'b0;
    tick();
    tripPinN = 1'b1;
    chk("R8 no pulse while flag set", 8'(tripIrq), 8'h0);
    clrWr = 1'b1; clrMask = 5'b00001;
    tick();
    clrWr = 1'b0; clrMask = '0;
    chk("R9 re-pulse", 8'(tripIrq), 8'h1);
    chk("R9 int flag kept", 8'(flags[0]), 8'h1);
    tick();
    clearAll();
    chk("R9 no pulse on full clear", 8'(tripIrq), 8'h0);
    chk("R9 all flags clear", 8'(flags), 8'h00);

    // R10 set beats clear
    tripPinN = 1'b0; clrWr = 1'b1; clrMask = 5'b00010;
    tick();
    tripPinN = 1'b1; clrWr = 1'b0; clrMask = '0;
    chk("R10 one-shot flag wins", 8'(flags[1]), 8'h1);
    clearAll();
    ostEn = '0;
    tick();

    // R12 disabled cause
    intEn = '0; dcSelA = 4'b0001;
    tripLinesN = 4'b1110;
    tick();
    tripLinesN = '1;
    chk("R12 flag set", 8'(flags[3]), 8'h1);
    chk("R12 no pulse", 8'(tripIrq), 8'h0);
    tick();
    chk("R12 int flag clear", 8'(flags[0]), 8'h0);
    chk("R12 still no pulse", 8'(tripIrq), 8'h0);
    clearAll();

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule